// File: doc/BRIEF.md
# Two-Output Minimal-Filtering Convolution Unit

This block evaluates a 3-tap convolution two results at a time. Each cycle it can take a group of four consecutive signed samples. The group holds two overlapping length-3 windows, and the block returns the inner product of the filter with each window. It uses a minimal-filtering decomposition, so the two results need only four multipliers instead of six. The price is a few extra adders on each side of the multipliers.

The three filter taps are written through a separate load port. They are converted into four pre-scaled multiplier operands once, when they are written, so no filter arithmetic sits in the per-sample path. Sample groups arrive on a valid/ready stream. They pass through three register stages: input transform, multiply, output transform. The two results leave together under one valid flag, and a new group can enter every cycle.

Top module: `winograd_pair_fir`

## Requirements
- R1: While reset is asserted, `outValid` and `inReady` are low, and the stored taps are cleared to zero. A group sent before any tap load returns 0 on both outputs.
- R2: `outY0` equals tap0*s0 + tap1*s1 + tap2*s2, where s0..s3 are `inSamp0`..`inSamp3` of the accepted group.
- R3: `outY1` equals tap0*s1 + tap1*s2 + tap2*s3 for the same group.
- R4: A group accepted at clock edge k (`inValid` and `inReady` both high) shows its results with `outValid` high in the cycle that follows edge k+2, which is a latency of three edges.
- R5: From the first edge after reset is released, `inReady` stays high, and groups presented on consecutive cycles are all accepted and all produce results on consecutive cycles.
- R6: A tap load (`wLoad` high at an edge) applies only to groups accepted at later edges. A group accepted at the same edge as the load, and every group already in the pipeline, completes with the previous taps.
- R7: All arithmetic is exact for every signed input and tap value, including all-minimum operands and alternating extremes. The outputs are DATA_W+COEF_W+2 bits wide.
- R8: `outValid` is high only for cycles that correspond to an accepted group. Idle input cycles produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wLoad | input | 1 | Writes the three taps at this edge |
| wTap0 | input | COEF_W | Tap multiplying the oldest window sample, signed |
| wTap1 | input | COEF_W | Middle tap, signed |
| wTap2 | input | COEF_W | Tap multiplying the newest window sample, signed |
| inValid | input | 1 | Sample group present |
| inReady | output | 1 | Block accepts a group this cycle |
| inSamp0 | input | DATA_W | Oldest sample of the group, signed |
| inSamp1 | input | DATA_W | Second sample, signed |
| inSamp2 | input | DATA_W | Third sample, signed |
| inSamp3 | input | DATA_W | Newest sample, signed |
| outValid | output | 1 | Result pair present |
| outY0 | output | DATA_W+COEF_W+2 | Result of window s0..s2, signed |
| outY1 | output | DATA_W+COEF_W+2 | Result of window s1..s3, signed |

## Verification
The assertions assume that reset is held for at least one edge before any traffic. They also assume that `inValid`, `wLoad`, taps and samples are never unknown at an edge, because the result check compares against a direct dot product formed from the port values three edges earlier. The stimulus therefore drives every input to a defined value from time zero and keeps it defined for the whole run. Idle cycles park `inValid` and `wLoad` low, and the sample and tap buses keep their last value.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  // number of multiplier lanes in the minimal-filtering datapath
  localparam int LANES = 4;
  // register stages from acceptance to result
  localparam int PIPE_DEPTH = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadW;  // write transformed taps into the bank
    logic cap1;   // capture input transform and tap snapshot
    logic cap2;   // capture lane products
    logic cap3;   // capture output transform
  } strobe_t;
endpackage

// File: rtl/wpf_ctrl.sv
module wpf_ctrl #(
  parameter int STAGES = wpf_pkg::PIPE_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             wLoad,
  output logic             inReady,
  output logic             outValid,
  output wpf_pkg::strobe_t stb
);
  logic              readyQ;
  logic [STAGES-1:0] vPipe;
  logic              accept;

  assign accept = inValid & readyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ <= 1'b0;
      vPipe  <= '0;
    end else begin
      readyQ <= 1'b1;
      vPipe  <= {vPipe[STAGES-2:0], accept};
    end
  end

  always_comb begin
    stb.loadW = wLoad & ~rst;
    stb.cap1  = accept;
    stb.cap2  = vPipe[0];
    stb.cap3  = vPipe[1];
  end

  assign inReady  = readyQ;
  assign outValid = vPipe[STAGES-1];
endmodule

// File: rtl/wpf_datapath.sv
module wpf_datapath #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int OUT_W  = DATA_W + COEF_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  wpf_pkg::strobe_t         stb,
  input  logic signed [COEF_W-1:0] tapA,
  input  logic signed [COEF_W-1:0] tapB,
  input  logic signed [COEF_W-1:0] tapC,
  input  logic signed [DATA_W-1:0] s0,
  input  logic signed [DATA_W-1:0] s1,
  input  logic signed [DATA_W-1:0] s2,
  input  logic signed [DATA_W-1:0] s3,
  output logic signed [OUT_W-1:0]  y0,
  output logic signed [OUT_W-1:0]  y1
);
  localparam int LANES = wpf_pkg::LANES;
  // transformed samples grow one bit
  localparam int T_W = DATA_W + 1;
  // taps carry one fractional bit and the three-tap sum
  localparam int G_W = COEF_W + 2;
  // lane product width; equals OUT_W + 1 (the fractional bit)
  localparam int P_W = T_W + G_W;

  // ---------------- tap transform, at load time only ----------------
  logic signed [G_W-1:0] gA, gB, gC;
  logic signed [G_W-1:0] gNew  [LANES];
  logic signed [G_W-1:0] wBank [LANES];

  assign gA = {{2{tapA[COEF_W-1]}}, tapA};
  assign gB = {{2{tapB[COEF_W-1]}}, tapB};
  assign gC = {{2{tapC[COEF_W-1]}}, tapC};

  // every operand is stored times two so the halves stay integers
  always_comb begin
    gNew[0] = gA <<< 1;
    gNew[1] = gA + gB + gC;
    gNew[2] = gA - gB + gC;
    gNew[3] = gC <<< 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LANES; i++) wBank[i] <= '0;
    end else if (stb.loadW) begin
      for (int i = 0; i < LANES; i++) wBank[i] <= gNew[i];
    end
  end

  // ---------------- stage 1: input transform ----------------
  logic signed [T_W-1:0] e0, e1, e2, e3;
  logic signed [T_W-1:0] tNext [LANES];
  logic signed [T_W-1:0] tReg  [LANES];
  logic signed [G_W-1:0] wSnap [LANES];

  assign e0 = {s0[DATA_W-1], s0};
  assign e1 = {s1[DATA_W-1], s1};
  assign e2 = {s2[DATA_W-1], s2};
  assign e3 = {s3[DATA_W-1], s3};

  always_comb begin
    tNext[0] = e0 - e2;
    tNext[1] = e1 + e2;
    tNext[2] = e2 - e1;
    tNext[3] = e1 - e3;
  end

  // the bank is snapshotted with the group so a later load cannot reach it
  always_ff @(posedge clk) begin
    if (stb.cap1) begin
      for (int i = 0; i < LANES; i++) begin
        tReg[i]  <= tNext[i];
        wSnap[i] <= wBank[i];
      end
    end
  end

  // ---------------- stage 2: one multiplier per lane ----------------
  logic signed [P_W-1:0] mVal [LANES];

  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic signed [P_W-1:0] tx, wx, prod;
    assign tx = {{G_W{tReg[i][T_W-1]}}, tReg[i]};
    assign wx = {{T_W{wSnap[i][G_W-1]}}, wSnap[i]};
    always_ff @(posedge clk) begin
      if (stb.cap2) prod <= tx * wx;
    end
    assign mVal[i] = prod;
  end

  // ---------------- stage 3: output transform ----------------
  // partial sums may wrap; the final doubled value always fits P_W
  logic signed [P_W-1:0] y0Sum, y1Sum;
  logic                  unusedLsbs;

  assign y0Sum = mVal[0] + mVal[1] + mVal[2];
  assign y1Sum = mVal[1] - mVal[2] - mVal[3];
  assign unusedLsbs = y0Sum[0] ^ y1Sum[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      y0 <= '0;
      y1 <= '0;
    end else if (stb.cap3) begin
      y0 <= y0Sum[P_W-1:1];
      y1 <= y1Sum[P_W-1:1];
    end
  end
endmodule

// File: rtl/winograd_pair_fir.sv
module winograd_pair_fir #(
  parameter  int DATA_W = 8,
  parameter  int COEF_W = 8,
  localparam int OUT_W  = DATA_W + COEF_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wLoad,
  input  logic signed [COEF_W-1:0] wTap0,
  input  logic signed [COEF_W-1:0] wTap1,
  input  logic signed [COEF_W-1:0] wTap2,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DATA_W-1:0] inSamp0,
  input  logic signed [DATA_W-1:0] inSamp1,
  input  logic signed [DATA_W-1:0] inSamp2,
  input  logic signed [DATA_W-1:0] inSamp3,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outY0,
  output logic signed [OUT_W-1:0]  outY1
);
  wpf_pkg::strobe_t stb;

  wpf_ctrl #(.STAGES(wpf_pkg::PIPE_DEPTH)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .wLoad    (wLoad),
    .inReady  (inReady),
    .outValid (outValid),
    .stb      (stb)
  );

  wpf_datapath #(.DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) uDp (
    .clk  (clk),
    .rst  (rst),
    .stb  (stb),
    .tapA (wTap0),
    .tapB (wTap1),
    .tapC (wTap2),
    .s0   (inSamp0),
    .s1   (inSamp1),
    .s2   (inSamp2),
    .s3   (inSamp3),
    .y0   (outY0),
    .y1   (outY1)
  );
endmodule

// File: rtl/wpf_chk.sv
module wpf_chk #(
  parameter  int DATA_W = 8,
  parameter  int COEF_W = 8,
  localparam int OUT_W  = DATA_W + COEF_W + 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wLoad,
  input logic signed [COEF_W-1:0] wTap0,
  input logic signed [COEF_W-1:0] wTap1,
  input logic signed [COEF_W-1:0] wTap2,
  input logic                     inValid,
  input logic                     inReady,
  input logic signed [DATA_W-1:0] inSamp0,
  input logic signed [DATA_W-1:0] inSamp1,
  input logic signed [DATA_W-1:0] inSamp2,
  input logic signed [DATA_W-1:0] inSamp3,
  input logic                     outValid,
  input logic signed [OUT_W-1:0]  outY0,
  input logic signed [OUT_W-1:0]  outY1
);
  localparam int DX = OUT_W - DATA_W;
  localparam int CX = OUT_W - COEF_W;

  // shadow of the taps as seen at the ports
  logic signed [COEF_W-1:0] sh0, sh1, sh2;
  always_ff @(posedge clk) begin
    if (rst) begin
      sh0 <= '0; sh1 <= '0; sh2 <= '0;
    end else if (wLoad) begin
      sh0 <= wTap0; sh1 <= wTap1; sh2 <= wTap2;
    end
  end

  logic signed [OUT_W-1:0] a0, a1, a2, a3, b0, b1, b2, ref0, ref1;
  assign a0 = {{DX{inSamp0[DATA_W-1]}}, inSamp0};
  assign a1 = {{DX{inSamp1[DATA_W-1]}}, inSamp1};
  assign a2 = {{DX{inSamp2[DATA_W-1]}}, inSamp2};
  assign a3 = {{DX{inSamp3[DATA_W-1]}}, inSamp3};
  assign b0 = {{CX{sh0[COEF_W-1]}}, sh0};
  assign b1 = {{CX{sh1[COEF_W-1]}}, sh1};
  assign b2 = {{CX{sh2[COEF_W-1]}}, sh2};
  assign ref0 = a0 * b0 + a1 * b1 + a2 * b2;
  assign ref1 = a1 * b0 + a2 * b1 + a3 * b2;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && !inReady));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    outValid == $past(inValid && inReady, 3));

  // R5
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> inReady);

  // R6
  pair_value_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outY0 == $past(ref0, 3) && outY1 == $past(ref1, 3)));
endmodule

bind winograd_pair_fir wpf_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) uChk (.*);

// File: tb/sim_winograd_pair_fir.sv
`timescale 1ns/1ps
module sim_winograd_pair_fir;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int OW = DW + CW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wLoad = 1'b0;
  logic signed [CW-1:0] wTap0 = '0, wTap1 = '0, wTap2 = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic signed [DW-1:0] inSamp0 = '0, inSamp1 = '0, inSamp2 = '0, inSamp3 = '0;
  logic outValid;
  logic signed [OW-1:0] outY0, outY1;

  always #10 clk = ~clk;

  winograd_pair_fir #(.DATA_W(DW), .COEF_W(CW)) u0 (.*);

  typedef struct { int y0; int y1; int cyc; string tag; } exp_t;
  exp_t sb[$];

  int cycleCnt = 0;
  int checks = 0;
  int fails = 0;
  int curW0 = 0, curW1 = 0, curW2 = 0;
  bit finished = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // one cycle of stimulus; a load and a group may share the cycle
  task automatic step(bit doLoad, int w0, int w1, int w2,
                      bit doSend, int d0, int d1, int d2, int d3, string tag);
    exp_t e;
    @(negedge clk);
    wLoad = doLoad;
    if (doLoad) begin
      wTap0 = CW'(w0); wTap1 = CW'(w1); wTap2 = CW'(w2);
    end
    inValid = doSend;
    if (doSend) begin
      inSamp0 = DW'(d0); inSamp1 = DW'(d1); inSamp2 = DW'(d2); inSamp3 = DW'(d3);
      // direct reference: six products, old taps if loaded this cycle (R6)
      e.y0 = curW0 * d0 + curW1 * d1 + curW2 * d2;
      e.y1 = curW0 * d1 + curW1 * d2 + curW2 * d3;
      e.cyc = cycleCnt + 3;
      e.tag = tag;
      sb.push_back(e);
    end
    if (doLoad) begin
      curW0 = w0; curW1 = w1; curW2 = w2;
    end
  endtask

  task automatic send(int d0, int d1, int d2, int d3, string tag);
    step(0, 0, 0, 0, 1, d0, d1, d2, d3, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic load(int w0, int w1, int w2);
    step(1, w0, w1, w2, 0, 0, 0, 0, 0, "");
  endtask

  function automatic int rs(int lo, int hi);
    return lo + int'($urandom_range(0, hi - lo));
  endfunction

  // monitor: pop and compare each result pair
  always @(negedge clk) begin
    if (!rst && outValid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected result y0=%0d y1=%0d expected no output",
                 $signed(outY0), $signed(outY1));
      end else begin
        e = sb.pop_front();
        if (int'($signed(outY0)) != e.y0 || int'($signed(outY1)) != e.y1 ||
            cycleCnt != e.cyc) begin
          fails++;
          $display("FAIL R2/R3/R4 %s y0=%0d y1=%0d cyc=%0d expected y0=%0d y1=%0d cyc=%0d",
                   e.tag, $signed(outY0), $signed(outY1), cycleCnt, e.y0, e.y1, e.cyc);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired, actual hung expected done");
      report();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset outValid=%b inReady=%b expected 0 0", outValid, inReady);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (inReady !== 1'b1) begin
      fails++;
      $display("FAIL R5 inReady=%b expected 1 after reset", inReady);
    end
    // R1: cleared taps give zero results
    send(100, -7, 55, -128, "R1_zero_taps");
    idle(4);

    // R2 R3 R5: back-to-back groups with fixed taps
    load(3, -5, 7);
    for (int i = 0; i < 20; i++)
      send(rs(-128, 127), rs(-128, 127), rs(-128, 127), rs(-128, 127), "R5_burst");

    // R8: bubbles between groups
    for (int i = 0; i < 10; i++) begin
      send(rs(-128, 127), rs(-128, 127), rs(-128, 127), rs(-128, 127), "R8_bubble");
      idle(i % 3 + 1);
    end
    idle(5);

    // R6: load in the same cycle as a group, groups in flight before it
    send(10, 20, 30, 40, "R6_inflight_a");
    send(-11, 12, -13, 14, "R6_inflight_b");
    step(1, -9, 4, 2, 1, 1, 2, 3, 4, "R6_same_cycle");
    send(1, 2, 3, 4, "R6_after_load");
    send(-50, 60, -70, 80, "R6_after_load2");
    idle(5);

    // R7: extreme operands
    load(-128, -128, -128);
    send(-128, -128, -128, -128, "R7_all_min");
    send(127, 127, 127, 127, "R7_min_taps_max_data");
    load(127, -128, 127);
    send(-128, 127, -128, 127, "R7_alternating");
    send(127, -128, 127, -128, "R7_alternating_inv");
    load(127, 127, 127);
    send(127, 127, 127, 127, "R7_all_max");
    send(-128, -128, -128, -128, "R7_max_taps_min_data");
    idle(5);

    // mixed random traffic with occasional reloads
    for (int i = 0; i < 300; i++) begin
      bit ld = ($urandom_range(0, 15) == 0);
      bit sd = ($urandom_range(0, 3) != 0);
      step(ld, rs(-128, 127), rs(-128, 127), rs(-128, 127),
           sd, rs(-128, 127), rs(-128, 127), rs(-128, 127), rs(-128, 127), "R2_R3_random");
    end
    idle(8);

    // R8: every accepted group produced exactly one result
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R8 %0d results missing, expected 0", sb.size());
    end
    report();
  end
endmodule